// File: doc/BRIEF.md
# Multiplexed GPIO Bank Controller

This block manages a bank of general-purpose pins. Each pin is owned either by the bank's own GPIO logic or by one of two internal peripheral functions, A or B. Software programs each per-pin attribute through a set/clear register pair and reads the attribute back from a status word. The attributes are ownership, output enable, output value, change-interrupt mask, pull-up, input filter, open-drain and peripheral choice. The bank drives pad output, pad output-enable and pull-up controls for every pin.

Pad inputs are synchronised and can optionally be glitch-filtered. The resulting level is readable at all times and is also passed to the peripherals. Every level change of a pin, rising or falling, is latched into a change-status word. Reading that word clears it. A single interrupt line is raised while any latched change is also unmasked.

The register interface is a simple valid/write bus with byte addresses. Read data is valid combinationally in the same cycle as the read request. Every register is one 32-bit word.

Top module: `mux_gpio_bank`

## Requirements
- R1: After reset all pins are GPIO-owned (ownership status all 1) with pull-ups on (pull-up status all 1). Output enable, output value, interrupt mask, filter, open-drain, peripheral choice and change status all read 0, pad_oe is 0 and irq is low.
- R2: Each attribute uses three consecutive words: write-set, write-clear and status. A 1 written to the set word sets that pin's bit and a 1 written to the clear word clears it, while 0 bits leave it unchanged. Byte offsets of the three words: ownership 0x00/0x04/0x08, output enable 0x0C/0x10/0x14, output value 0x18/0x1C/0x20, interrupt mask 0x24/0x28/0x2C, pull-up 0x30/0x34/0x38, filter 0x3C/0x40/0x44, open-drain 0x48/0x4C/0x50.
- R3: An ownership status bit of 1 means the pin is GPIO-owned. A bit of 0 means the pin is handed to a peripheral.
- R4: Peripheral choice is written at 0x54 (select B) and 0x58 (select A). Its status at 0x5C reads 1 for B and 0 for A.
- R5: A GPIO-owned pin drives pad_oe from its output enable and pad_out from its output value. A peripheral-owned pin passes pa_out/pa_oe through when set to A, and pb_out/pb_oe when set to B.
- R6: A GPIO-owned, output-enabled pin with open-drain set never drives high. For output value 1 it releases the pad (pad_oe 0), and for value 0 it drives low (pad_oe 1, pad_out 0).
- R7: pad_pullup equals the pull-up status word.
- R8: The pin level word at 0x60 and periph_in show the synchronised pad level whatever the pin's owner. On an unfiltered pin, a pad change set up before clock edge k appears after edge k+2.
- R9: On a filtered pin a level change is accepted only once the synchronised input has held the same value on two consecutive clocks. This adds one cycle of latency, and a pulse one clock long is ignored.
- R10: Both rising and falling level changes set the pin's bit in the change status word at 0x64.
- R11: Reading 0x64 returns the latched changes and clears them. A change arriving in the same cycle as the read stays latched.
- R12: irq is high exactly when some pin has both its change bit and its mask bit set.
- R13: Writes to status, level or change words change nothing. Reads of unmapped or misaligned addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 9 | Byte address |
| bus_wdata | input | 32 | Write data, bit n = pin n |
| bus_rdata | output | 32 | Read data, valid in the request cycle |
| pad_in | input | 32 | Raw pad input levels |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |
| pad_pullup | output | 32 | Pad pull-up enables |
| pa_out | input | 32 | Peripheral A drive values |
| pa_oe | input | 32 | Peripheral A drive enables |
| pb_out | input | 32 | Peripheral B drive values |
| pb_oe | input | 32 | Peripheral B drive enables |
| periph_in | output | 32 | Synchronised and filtered pin levels for peripherals |
| irq | output | 1 | Bank change interrupt |

## Verification
The pad mux is exercised with opposite bit patterns on the two peripheral buses and a GPIO output pattern distinct from both. This shows which source reaches each pin in GPIO, A, B and open-drain modes. Input timing is probed with a single step read back on successive cycles, which separates the unfiltered and filtered latencies. A one-clock pulse applied to a filtered pin and an unfiltered pin at once shows the filter rejecting what the plain path latches. Edges of both polarities, one edge landing exactly on a status read, and mask toggling with a pending change cover latching, clear-on-read and interrupt gating.

// File: rtl/mux_gpio_bank.sv
module mux_gpio_bank #(
  parameter int NPINS = 32,
  parameter int AW    = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_valid,
  input  logic             bus_write,
  input  logic [AW-1:0]    bus_addr,
  input  logic [NPINS-1:0] bus_wdata,
  output logic [NPINS-1:0] bus_rdata,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_pullup,
  input  logic [NPINS-1:0] pa_out,
  input  logic [NPINS-1:0] pa_oe,
  input  logic [NPINS-1:0] pb_out,
  input  logic [NPINS-1:0] pb_oe,
  output logic [NPINS-1:0] periph_in,
  output logic             irq
);

  localparam int WI    = AW - 2;
  localparam int NATTR = 8;
  localparam int K_OWN = 0, K_OE = 1, K_OUT = 2, K_IE = 3;
  localparam int K_PU  = 4, K_FLT = 5, K_OD = 6, K_SEL = 7;
  localparam logic [NATTR-1:0] RST_ONES = NATTR'((1 << K_OWN) | (1 << K_PU));
  localparam logic [WI-1:0] W_LVL    = WI'(3 * NATTR);
  localparam logic [WI-1:0] W_CHG    = WI'(3 * NATTR + 1);
  localparam logic [WI-1:0] W_OE_SET = WI'(3 * K_OE);
  localparam logic [WI-1:0] W_OE_CLR = WI'(3 * K_OE + 1);

  logic [NPINS-1:0] cfg [NATTR];
  logic [NPINS-1:0] s1, s2, s3, lvl, lvl_d, chg, chg_d;
  logic [NPINS-1:0] own, oe, dout, ie, pu, flt, od, sel;
  logic [NPINS-1:0] stable, per_out, per_oe;
  logic [WI-1:0]    widx;
  logic             aligned, wr, rd, chg_rd;

  assign widx    = bus_addr[AW-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wr      = bus_valid & bus_write & aligned;
  assign rd      = bus_valid & ~bus_write & aligned;
  assign chg_rd  = rd && (widx == W_CHG);

  assign own  = cfg[K_OWN];
  assign oe   = cfg[K_OE];
  assign dout = cfg[K_OUT];
  assign ie   = cfg[K_IE];
  assign pu   = cfg[K_PU];
  assign flt  = cfg[K_FLT];
  assign od   = cfg[K_OD];
  assign sel  = cfg[K_SEL];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NATTR; k++) cfg[k] <= {NPINS{RST_ONES[k]}};
    end else begin
      for (int k = 0; k < NATTR; k++) begin
        if (wr && widx == WI'(3 * k))          cfg[k] <= cfg[k] | bus_wdata;
        else if (wr && widx == WI'(3 * k + 1)) cfg[k] <= cfg[k] & ~bus_wdata;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      for (int k = 0; k < NATTR; k++)
        if (widx == WI'(3 * k + 2)) bus_rdata = cfg[k];
      if (widx == W_LVL) bus_rdata = lvl;
      if (widx == W_CHG) bus_rdata = chg;
    end
  end

  assign stable = ~(s2 ^ s3);
  assign lvl_d  = (~flt & s2) | (flt & ((stable & s2) | (~stable & lvl)));
  assign chg_d  = (chg_rd ? '0 : chg) | (lvl_d ^ lvl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1  <= '0;
      s2  <= '0;
      s3  <= '0;
      lvl <= '0;
      chg <= '0;
    end else begin
      s1  <= pad_in;
      s2  <= s1;
      s3  <= s2;
      lvl <= lvl_d;
      chg <= chg_d;
    end
  end

  assign per_out    = (sel & pb_out) | (~sel & pa_out);
  assign per_oe     = (sel & pb_oe)  | (~sel & pa_oe);
  assign pad_oe     = (own & oe & (~od | ~dout)) | (~own & per_oe);
  assign pad_out    = (own & ~od & dout) | (~own & per_out);
  assign pad_pullup = pu;
  assign periph_in  = lvl;
  assign irq        = |(chg & ie);

  a_r2_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && widx == W_OE_SET) |=> ((oe & $past(bus_wdata)) == $past(bus_wdata)));

  a_r2_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && widx == W_OE_CLR) |=> ((oe & $past(bus_wdata)) == '0));

  a_r11_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    chg_rd |=> ((chg & ~(lvl ^ $past(lvl))) == '0));

  a_r10_edge_latched: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((lvl ^ $past(lvl)) & ~chg) == '0));

  a_r12_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (ie == '0) |-> !irq);

  a_r6_od_never_high: assert property (@(posedge clk) disable iff (!rst_n)
    ((own & oe & od) & pad_oe & pad_out) == '0);

  a_r5_periph_a_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (own == '0 && sel == '0) |-> (pad_oe == pa_oe && pad_out == pa_out));

endmodule

// File: tb/mux_gpio_bank_tb.sv
module mux_gpio_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [31:0] pad_in = '0, pad_out, pad_oe, pad_pullup, periph_in;
  logic [31:0] pa_out = '0, pa_oe = '0, pb_out = '0, pb_oe = '0;
  logic        irq;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  mux_gpio_bank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pullup(pad_pullup),
    .pa_out(pa_out), .pa_oe(pa_oe), .pb_out(pb_out), .pb_oe(pb_oe),
    .periph_in(periph_in), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk);
    #1 bus_valid = 1'b0;
  endtask

  task automatic rdchk(input string req, input logic [8:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic t_reset;
    rdchk("R1 own", 9'h008, 32'hFFFF_FFFF);
    rdchk("R1 oe",  9'h014, 32'h0);
    rdchk("R1 out", 9'h020, 32'h0);
    rdchk("R1 ie",  9'h02C, 32'h0);
    rdchk("R1 pu",  9'h038, 32'hFFFF_FFFF);
    rdchk("R1 flt", 9'h044, 32'h0);
    rdchk("R1 od",  9'h050, 32'h0);
    rdchk("R1 sel", 9'h05C, 32'h0);
    rdchk("R1 chg", 9'h064, 32'h0);
    chk("R1 pad_oe", pad_oe, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_setclr;
    wr(9'h018, 32'h0000_00F0);
    rdchk("R2 set", 9'h020, 32'h0000_00F0);
    wr(9'h018, 32'h0000_0F00);
    rdchk("R2 set accumulates", 9'h020, 32'h0000_0FF0);
    wr(9'h01C, 32'h0000_0030);
    rdchk("R2 clear", 9'h020, 32'h0000_0FC0);
    wr(9'h018, 32'h0);
    rdchk("R2 zero write", 9'h020, 32'h0000_0FC0);
    wr(9'h020, 32'hFFFF_FFFF);
    rdchk("R13 status write ignored", 9'h020, 32'h0000_0FC0);
    wr(9'h01C, 32'hFFFF_FFFF);
    rdchk("R2 clear all", 9'h020, 32'h0);
    rdchk("R13 unmapped", 9'h1F0, 32'h0);
    rdchk("R13 misaligned", 9'h009, 32'h0);
  endtask

  task automatic t_drive;
    pa_out = 32'hAAAA_AAAA; pa_oe = 32'h0000_FFFF;
    pb_out = 32'h5555_5555; pb_oe = 32'hFFFF_0000;
    wr(9'h00C, 32'h0000_000F);
    wr(9'h018, 32'h0000_0005);
    chk("R5 gpio oe", pad_oe, 32'h0000_000F);
    chk("R5 gpio out", pad_out, 32'h0000_0005);
    wr(9'h048, 32'h0000_0003);
    chk("R6 od oe", pad_oe, 32'h0000_000E);
    chk("R6 od out", pad_out, 32'h0000_0004);
    wr(9'h004, 32'h0000_FF00);
    rdchk("R3 own status", 9'h008, 32'hFFFF_00FF);
    chk("R5 periph A oe", pad_oe, 32'h0000_FF0E);
    chk("R5 periph A out", pad_out, 32'h0000_AA04);
    wr(9'h054, 32'h0000_0F00);
    rdchk("R4 sel B status", 9'h05C, 32'h0000_0F00);
    chk("R5 periph B oe", pad_oe, 32'h0000_F00E);
    chk("R5 periph B out", pad_out, 32'h0000_A504);
    wr(9'h058, 32'h0000_0100);
    rdchk("R4 sel A status", 9'h05C, 32'h0000_0E00);
    chk("R4 back to A oe", pad_oe, 32'h0000_F10E);
    chk("R4 back to A out", pad_out, 32'h0000_A404);
    wr(9'h000, 32'hFFFF_FFFF);
    wr(9'h010, 32'hFFFF_FFFF);
    wr(9'h01C, 32'hFFFF_FFFF);
    wr(9'h04C, 32'hFFFF_FFFF);
    wr(9'h058, 32'hFFFF_FFFF);
    chk("R5 restored oe", pad_oe, 32'h0);
    wr(9'h034, 32'h0000_FFFF);
    chk("R7 pullup", pad_pullup, 32'hFFFF_0000);
    wr(9'h030, 32'h0000_FFFF);
    chk("R7 pullup back", pad_pullup, 32'hFFFF_FFFF);
  endtask

  task automatic t_level;
    logic [31:0] d;
    @(negedge clk); pad_in[0] = 1'b1;
    rd(9'h060, d); chk("R8 unfiltered e1", d & 32'h1, 32'h0);
    rd(9'h060, d); chk("R8 unfiltered e2", d & 32'h1, 32'h0);
    rd(9'h060, d); chk("R8 unfiltered e3", d & 32'h1, 32'h1);
    wr(9'h03C, 32'h0000_0002);
    @(negedge clk); pad_in[1] = 1'b1;
    rd(9'h060, d); chk("R9 filtered e1", d & 32'h2, 32'h0);
    rd(9'h060, d); chk("R9 filtered e2", d & 32'h2, 32'h0);
    rd(9'h060, d); chk("R9 filtered e3", d & 32'h2, 32'h0);
    rd(9'h060, d); chk("R9 filtered e4", d & 32'h2, 32'h2);
    wr(9'h004, 32'h0000_0004);
    @(negedge clk); pad_in[2] = 1'b1;
    idle(5);
    rd(9'h060, d); chk("R8 periph-owned level", d & 32'h4, 32'h4);
    chk("R8 periph_in", periph_in & 32'h7, 32'h7);
    wr(9'h000, 32'h0000_0004);
    rdchk("R10 rising edges", 9'h064, 32'h0000_0007);
  endtask

  task automatic t_glitch;
    logic [31:0] d;
    wr(9'h03C, 32'h0000_0010);
    @(negedge clk); pad_in[5:4] = 2'b11;
    @(negedge clk); pad_in[5:4] = 2'b00;
    idle(8);
    rdchk("R9 pulse rejected only when filtered", 9'h064, 32'h0000_0020);
    rd(9'h060, d); chk("R9 pulse level", d & 32'h30, 32'h0);
  endtask

  task automatic t_fall;
    @(negedge clk); pad_in[0] = 1'b0;
    idle(5);
    rdchk("R10 falling edge", 9'h064, 32'h0000_0001);
    rdchk("R11 cleared by read", 9'h064, 32'h0);
  endtask

  task automatic t_coincide;
    @(negedge clk); pad_in[6] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    rdchk("R11 read before edge", 9'h064, 32'h0);
    rdchk("R11 edge during read kept", 9'h064, 32'h0000_0040);
  endtask

  task automatic t_irq;
    @(negedge clk); pad_in[6] = 1'b0;
    idle(5);
    chk("R12 masked", {31'h0, irq}, 32'h0);
    wr(9'h024, 32'h0000_0040);
    chk("R12 unmasked", {31'h0, irq}, 32'h1);
    rdchk("R12 mask status", 9'h02C, 32'h0000_0040);
    wr(9'h028, 32'h0000_0040);
    chk("R12 masked again", {31'h0, irq}, 32'h0);
    wr(9'h024, 32'h0000_0080);
    chk("R12 other pin masked in", {31'h0, irq}, 32'h0);
    wr(9'h024, 32'h0000_0040);
    chk("R12 reasserted", {31'h0, irq}, 32'h1);
    rdchk("R11 pending change", 9'h064, 32'h0000_0040);
    chk("R12 drops after read", {31'h0, irq}, 32'h0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    @(negedge clk); rst_n = 1'b1;
    t_reset;
    t_setclr;
    t_drive;
    t_level;
    t_glitch;
    t_fall;
    t_coincide;
    t_irq;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule